// File: doc/BRIEF.md
# Supervised Loop State Classifier

This block watches one supervised input loop through a stream of ADC codes and turns it into a stable wiring state. Each code that arrives with a sample strobe is sorted into a window bin: Normal, Open, Short, Tamper (bypass) or SupervisionFail. A sample close to any threshold falls inside a guard band and counts toward no bin. A fault state is entered only after N consecutive samples in the same fault bin. Leaving a fault needs M consecutive Normal samples, and M is set separately from N.

Alongside the state, the block keeps the evidence a host needs to tell spikes from persistent faults. It records the timestamp of the first boundary crossing and the timestamp at which a fault latched. It counts fault entries, clock cycles spent in a fault and bin changes between samples. It also tracks the smallest distance seen between a sample and a threshold, and raises a drift warning when that distance falls below a programmable limit. The host loads every threshold, the guard width and the confirmation counts as plain inputs, and must keep the thresholds in ascending order.

Top module: `loop_state_classifier`

## Requirements
- R1: After reset the state is Normal (0), the fault, time-in-fault and bin-hop counters are zero, the minimum margin is all ones, no event is signalled and the warning is low.
- R2: A sampled code `c` is sorted into a bin with the state encoding Normal=0, Open=1, Short=2, Tamper=3, SupervisionFail=4:
  - `c <= rail_lo` or `c >= rail_hi` gives SupervisionFail.
  - otherwise `c < thr_st` gives Short, `c < thr_tn` gives Tamper, `c < thr_no` gives Normal, and any higher code gives Open.
- R3: A non-rail sample whose distance to `thr_st`, `thr_tn` or `thr_no` is less than `guard_w` is a guard sample. It belongs to no bin and resets the run of consistent samples.
- R4: A fault state (Open, Short, Tamper or SupervisionFail) is latched on the sample that completes `n_latch` consecutive samples in that bin. This applies from Normal and also from a different fault state.
- R5: A latched fault returns to Normal on the sample that completes `m_clear` consecutive Normal samples. Fewer Normal samples leave the fault in place.
- R6: A code in the bypass region between `thr_st` and `thr_tn` latches Tamper and is never reported as Short.
- R7: Every state change produces exactly one `evt_valid` pulse, one cycle long, in the cycle the new state appears. It carries `evt_code = {CH_ID, old state, new state}`, with 3 bits for each state field.
- R8: `cross_ts` captures `now_ts` from a non-Normal sample that follows a Normal-bin sample while the state is Normal. `latch_ts` captures `now_ts` from the sample that latches a fault.
- R9: `fault_cnt` counts fault latches. `hop_cnt` counts samples whose bin (with guard as its own bin) differs from the previous sample's bin.
- R10: `tif_cnt` increases by one on every clock while the state is not Normal. All counters saturate at all ones instead of wrapping.
- R11: `min_margin` keeps the smallest distance to the nearest threshold over all non-rail samples. `trouble` is high while `min_margin < margin_warn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_code | input | ADC_W | Loop-sense ADC code |
| now_ts | input | TS_W | Free-running timestamp |
| rail_lo | input | ADC_W | Codes at or below this are SupervisionFail |
| rail_hi | input | ADC_W | Codes at or above this are SupervisionFail |
| thr_st | input | ADC_W | Short / Tamper boundary |
| thr_tn | input | ADC_W | Tamper / Normal boundary |
| thr_no | input | ADC_W | Normal / Open boundary |
| guard_w | input | ADC_W | Guard half-width around each boundary |
| n_latch | input | CONF_W | Consecutive samples needed to latch a fault |
| m_clear | input | CONF_W | Consecutive Normal samples needed to clear |
| margin_warn | input | ADC_W | Margin below which the warning is raised |
| state | output | 3 | Latched wiring state |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_code | output | CH_W+6 | {channel, old state, new state} |
| cross_ts | output | TS_W | Timestamp of first boundary crossing |
| latch_ts | output | TS_W | Timestamp of last fault latch |
| fault_cnt | output | CNT_W | Fault entries |
| tif_cnt | output | CNT_W | Cycles spent in a fault |
| hop_cnt | output | CNT_W | Sample-to-sample bin changes |
| min_margin | output | ADC_W | Smallest distance to a threshold |
| trouble | output | 1 | Margin drift warning |

## Verification
The hardest situations to reach are the ones where a run of samples almost completes. The first is a guard sample arriving one sample before a Short run would latch. The second is a Normal run cut off by a guard sample just before it would clear. The third is one fault run replacing another latched fault without passing through Normal. The vector table builds each of these by feeding codes chosen in exact positions relative to the thresholds, and checks state and event on every sample. Counter saturation needs a long dwell in a fault, so a directed test latches Open and then holds idle past the counter's full range.

// File: rtl/loop_state_classifier.sv
module loop_state_classifier #(
  parameter int ADC_W  = 12,
  parameter int CONF_W = 8,
  parameter int CNT_W  = 16,
  parameter int TS_W   = 32,
  parameter int CH_W   = 4,
  parameter int CH_ID  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [ADC_W-1:0]  smp_code,
  input  logic [TS_W-1:0]   now_ts,
  input  logic [ADC_W-1:0]  rail_lo,
  input  logic [ADC_W-1:0]  rail_hi,
  input  logic [ADC_W-1:0]  thr_st,
  input  logic [ADC_W-1:0]  thr_tn,
  input  logic [ADC_W-1:0]  thr_no,
  input  logic [ADC_W-1:0]  guard_w,
  input  logic [CONF_W-1:0] n_latch,
  input  logic [CONF_W-1:0] m_clear,
  input  logic [ADC_W-1:0]  margin_warn,
  output logic [2:0]        state,
  output logic              evt_valid,
  output logic [CH_W+5:0]   evt_code,
  output logic [TS_W-1:0]   cross_ts,
  output logic [TS_W-1:0]   latch_ts,
  output logic [CNT_W-1:0]  fault_cnt,
  output logic [CNT_W-1:0]  tif_cnt,
  output logic [CNT_W-1:0]  hop_cnt,
  output logic [ADC_W-1:0]  min_margin,
  output logic              trouble
);

  localparam logic [2:0] S_NORM  = 3'd0;
  localparam logic [2:0] S_OPEN  = 3'd1;
  localparam logic [2:0] S_SHORT = 3'd2;
  localparam logic [2:0] S_TAMP  = 3'd3;
  localparam logic [2:0] S_SUPF  = 3'd4;
  localparam logic [2:0] B_GUARD = 3'd7;
  localparam logic [CH_W-1:0]   CH_TAG   = CH_W'(CH_ID);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [CONF_W-1:0] CONF_ONE = CONF_W'(1);

  logic [ADC_W-1:0]  d_st, d_tn, d_no, d_lo, near;
  logic              in_rail, in_guard;
  logic [2:0]        raw_bin, bin, run_bin, prev_bin, nxt_state;
  logic [CONF_W-1:0] run_len, next_len;
  logic              run_hit, fault_bin, go_fault, go_clear, do_change;

  assign d_st = (smp_code >= thr_st) ? smp_code - thr_st : thr_st - smp_code;
  assign d_tn = (smp_code >= thr_tn) ? smp_code - thr_tn : thr_tn - smp_code;
  assign d_no = (smp_code >= thr_no) ? smp_code - thr_no : thr_no - smp_code;
  assign d_lo = (d_st < d_tn) ? d_st : d_tn;
  assign near = (d_lo < d_no) ? d_lo : d_no;

  assign in_rail  = (smp_code <= rail_lo) || (smp_code >= rail_hi);
  assign in_guard = !in_rail && (near < guard_w);

  assign raw_bin = (smp_code < thr_st) ? S_SHORT :
                   (smp_code < thr_tn) ? S_TAMP  :
                   (smp_code < thr_no) ? S_NORM  : S_OPEN;
  assign bin = in_rail ? S_SUPF : (in_guard ? B_GUARD : raw_bin);

  assign run_hit  = (bin == run_bin) && (bin != B_GUARD);
  assign next_len = (bin == B_GUARD) ? '0 :
                    run_hit ? ((&run_len) ? run_len : run_len + CONF_ONE) : CONF_ONE;

  assign fault_bin = (bin != S_NORM) && (bin != B_GUARD);
  assign go_fault  = fault_bin && (bin != state) && (next_len >= n_latch);
  assign go_clear  = (state != S_NORM) && (bin == S_NORM) && (next_len >= m_clear);
  assign nxt_state = go_fault ? bin : (go_clear ? S_NORM : state);
  assign do_change = smp_valid && (go_fault || go_clear);

  assign trouble = (min_margin < margin_warn);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_NORM;
      evt_valid  <= 1'b0;
      evt_code   <= '0;
      cross_ts   <= '0;
      latch_ts   <= '0;
      fault_cnt  <= '0;
      tif_cnt    <= '0;
      hop_cnt    <= '0;
      min_margin <= '1;
      run_bin    <= S_NORM;
      run_len    <= '0;
      prev_bin   <= S_NORM;
    end else begin
      evt_valid <= do_change;
      if (do_change) begin
        state    <= nxt_state;
        evt_code <= {CH_TAG, state, nxt_state};
      end
      if (state != S_NORM && !(&tif_cnt))
        tif_cnt <= tif_cnt + CNT_ONE;
      if (smp_valid) begin
        run_bin  <= bin;
        run_len  <= next_len;
        prev_bin <= bin;
        if (bin != prev_bin && !(&hop_cnt))
          hop_cnt <= hop_cnt + CNT_ONE;
        if (!in_rail && near < min_margin)
          min_margin <= near;
        if (state == S_NORM && prev_bin == S_NORM && bin != S_NORM)
          cross_ts <= now_ts;
        if (go_fault) begin
          latch_ts <= now_ts;
          if (!(&fault_cnt))
            fault_cnt <= fault_cnt + CNT_ONE;
        end
      end
    end
  end

endmodule

// File: rtl/loop_state_classifier_chk.sv
module loop_state_classifier_chk #(
  parameter int ADC_W = 12,
  parameter int CNT_W = 16,
  parameter int CH_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic [2:0]       state,
  input logic             evt_valid,
  input logic [CH_W+5:0]  evt_code,
  input logic [CNT_W-1:0] fault_cnt,
  input logic [CNT_W-1:0] tif_cnt,
  input logic [ADC_W-1:0] min_margin
);

  a_r2_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    state <= 3'd4);

  a_r7_evt_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> state != $past(state));

  a_r7_change_has_evt: assert property (@(posedge clk) disable iff (!rst_n)
    state != $past(state) |-> evt_valid);

  a_r7_evt_fields: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_code[2:0] == state) && (evt_code[5:3] == $past(state)));

  a_r4_change_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
    state != $past(state) |-> $past(smp_valid));

  a_r10_no_wrap_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault_cnt >= $past(fault_cnt));

  a_r10_no_wrap_tif: assert property (@(posedge clk) disable iff (!rst_n)
    tif_cnt >= $past(tif_cnt));

  a_r11_margin_nonincr: assert property (@(posedge clk) disable iff (!rst_n)
    min_margin <= $past(min_margin));

endmodule

bind loop_state_classifier loop_state_classifier_chk #(
  .ADC_W(ADC_W), .CNT_W(CNT_W), .CH_W(CH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .state(state),
  .evt_valid(evt_valid), .evt_code(evt_code), .fault_cnt(fault_cnt),
  .tif_cnt(tif_cnt), .min_margin(min_margin)
);

// File: tb/loop_state_classifier_bench.sv
`timescale 1ns/1ps
module loop_state_classifier_bench;
  localparam int ADC_W = 12, CONF_W = 8, CNT_W = 16, TS_W = 32, CH_W = 4, CH_ID = 5;
  localparam int NV = 39;
  localparam int V_CODE [NV] = '{2200,3400,3400,3400,2200,2200,2200,2200,2200,
                                 400,400,1620,400,400,400,
                                 2200,2200,2200,2200,1620,2200,2200,2200,2200,2200,
                                 1200,1200,1200,400,400,400,4050,4050,4050,
                                 2200,2200,2200,2200,2200};
  localparam int V_ST [NV] = '{0,0,0,1,1,1,1,1,0,
                               0,0,0,0,0,2,
                               2,2,2,2,2,2,2,2,2,0,
                               0,0,3,3,3,2,2,2,4,
                               4,4,4,4,0};
  localparam int V_EV [NV] = '{0,0,0,1,0,0,0,0,1,
                               0,0,0,0,0,1,
                               0,0,0,0,0,0,0,0,0,1,
                               0,0,1,0,0,1,0,0,1,
                               0,0,0,0,1};

  logic clk = 1'b0, rst_n = 1'b0, smp_valid = 1'b0;
  logic [ADC_W-1:0] smp_code = '0;
  logic [TS_W-1:0] now_ts = '0;
  logic [ADC_W-1:0] rail_lo = 12'd100, rail_hi = 12'd3995, thr_st = 12'd800,
                    thr_tn = 12'd1600, thr_no = 12'd2800, guard_w = 12'd50,
                    margin_warn = 12'd100;
  logic [CONF_W-1:0] n_latch = 8'd3, m_clear = 8'd5;
  logic [2:0] state;
  logic evt_valid, trouble;
  logic [CH_W+5:0] evt_code;
  logic [TS_W-1:0] cross_ts, latch_ts;
  logic [CNT_W-1:0] fault_cnt, tif_cnt, hop_cnt;
  logic [ADC_W-1:0] min_margin;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  loop_state_classifier #(.ADC_W(ADC_W), .CONF_W(CONF_W), .CNT_W(CNT_W), .TS_W(TS_W),
                          .CH_W(CH_W), .CH_ID(CH_ID)) u_loop_state_classifier (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code), .now_ts(now_ts),
    .rail_lo(rail_lo), .rail_hi(rail_hi), .thr_st(thr_st), .thr_tn(thr_tn), .thr_no(thr_no),
    .guard_w(guard_w), .n_latch(n_latch), .m_clear(m_clear), .margin_warn(margin_warn),
    .state(state), .evt_valid(evt_valid), .evt_code(evt_code), .cross_ts(cross_ts),
    .latch_ts(latch_ts), .fault_cnt(fault_cnt), .tif_cnt(tif_cnt), .hop_cnt(hop_cnt),
    .min_margin(min_margin), .trouble(trouble));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_sample(input int code, input int ts);
    smp_code  = ADC_W'(code);
    now_ts    = TS_W'(ts);
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_reset_state();
    chk("R1 state", state, 0);
    chk("R1 fault_cnt", fault_cnt, 0);
    chk("R1 tif_cnt", tif_cnt, 0);
    chk("R1 hop_cnt", hop_cnt, 0);
    chk("R1 min_margin", min_margin, 4095);
    chk("R1 evt_valid", evt_valid, 0);
    chk("R1 trouble", trouble, 0);
  endtask

  initial begin
    int prev_st;
    @(negedge clk);
    do_reset();
    check_reset_state();

    // R2 R3 R4 R5 R6 R7: table walk
    prev_st = 0;
    for (int i = 0; i < NV; i++) begin
      do_sample(V_CODE[i], 10 * (i + 1));
      chk($sformatf("R2/R4/R5 vector %0d state", i + 1), state, V_ST[i]);
      chk($sformatf("R7 vector %0d evt_valid", i + 1), evt_valid, V_EV[i]);
      if (V_EV[i] != 0)
        chk($sformatf("R7 vector %0d evt_code", i + 1), evt_code,
            {CH_W'(CH_ID), 3'(prev_st), 3'(V_ST[i])});
      if (i == 13) chk("R3 guard broke Short run", state, 0);
      if (i == 27) chk("R6 bypass region is Tamper", state, 3);
      if (i == 10) begin
        chk("R11 margin before guard", min_margin, 400);
        chk("R11 trouble low", trouble, 0);
      end
      prev_st = V_ST[i];
    end

    chk("R8 cross_ts", cross_ts, 260);
    chk("R8 latch_ts", latch_ts, 340);
    chk("R9 fault_cnt", fault_cnt, 5);
    chk("R9 hop_cnt", hop_cnt, 12);
    chk("R10 tif_cnt", tif_cnt, 26);
    chk("R11 min_margin", min_margin, 20);
    chk("R11 trouble high", trouble, 1);
    @(negedge clk);
    chk("R7 single strobe", evt_valid, 0);

    // R1 again after a busy run
    do_reset();
    check_reset_state();

    // R10 saturation of time-in-fault
    for (int i = 0; i < 3; i++) do_sample(3400, 1000 + i);
    chk("R4 open latched", state, 1);
    repeat (70000) @(negedge clk);
    chk("R10 tif saturates", tif_cnt, 65535);
    chk("R10 state held", state, 1);
    chk("R9 one entry", fault_cnt, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule